// File: doc/BRIEF.md
# Sparse Pixel Cluster Selector

This block sits behind a bank of per-column converters in a pixel readout chain. Each accepted row step delivers one 5-bit sample for every column at once. The block looks for hits with a 2×2 summing window. The window is evaluated at every position of the row pair in parallel, and each sum is compared with one shared threshold. Every hit marks a 7×7 square of pixels around it. Only the marked pixels leave the block, so raw rows never stream out. This suits a detector that expects roughly one pixel in a hundred to carry signal.

A short line buffer holds the four most recent rows and the hit masks of the seven most recent window rows. Marks can therefore reach three rows above a hit and three rows below it before a row is released. When a row is released, every marked pixel in it is written, with its row number, into that column's own queue. A single output port with a valid/ready handshake drains the queues. The lowest-numbered column that holds data is always served first.

When a column queue is full, new pixels for that column are lost, and a sticky overflow output reports the loss.

Top module: `sparse_cluster_finder`

## Requirements
- R1: Each cycle with `row_valid` high accepts one row of `NCOL` samples, 5 bits each. Column c is held in bits [5c+4:5c]. Rows are numbered 0, 1, 2 … from reset, and the number wraps modulo 2^`ROW_W`.
- R2: The window anchored at row r and column c covers the pixels (r,c), (r,c+1), (r+1,c) and (r+1,c+1), for c from 0 to `NCOL`-2. It fires only when the unsigned 7-bit sum of those four pixels is strictly greater than `threshold`. A sum equal to `threshold` does not fire.
- R3: A window is compared against the `threshold` value present on the cycle its lower row (r+1) is accepted.
- R4: A window that fires at (r,c) marks every pixel in rows r-3 to r+3 and columns c-3 to c+3. The square is clipped at the array edges and at row 0.
- R5: Marks from overlapping squares merge, so each pixel is emitted at most once, carrying its own sample value.
- R6: Row j is released into the queues on the cycle that row j+4 is accepted. A row that has fewer than four later rows stays held.
- R7: Each column queue holds `FIFO_DEPTH` (default 132) entries and keeps them in release order.
- R8: `out_valid` is high whenever any queue holds data. The entry shown is the head of the lowest-numbered non-empty column. It leaves when `out_ready` is high at a clock edge.
- R9: A marked pixel released into a queue that was full before that edge is dropped. `overflow` then rises and stays high until reset.
- R10: After reset, every queue is empty and `out_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_valid | input | 1 | A row of samples is present this cycle |
| row_data | input | NCOL*5 | One sample per column |
| threshold | input | 7 | Hit threshold shared by all window positions |
| out_valid | output | 1 | An output entry is available |
| out_ready | input | 1 | Consumer accepts the entry |
| out_col | output | $clog2(NCOL) | Column of the entry |
| out_row | output | ROW_W | Row number of the entry |
| out_val | output | 5 | Sample value of the entry |
| overflow | output | 1 | Sticky flag: a marked pixel was dropped |

## Verification
The bench tries a lone window of exactly the threshold plus one, and then the same window at exactly the threshold. This separates a strict comparison from a non-strict one. Hits at the top row, the left edge and the right edge expose wrong clipping through their exact emitted counts (28, 28 and 35). Two overlapping hits give a 78-pixel union, which shows whether the marks are merged or emitted twice. A threshold that drops for a single row step shows whether the threshold is sampled when the window's lower row arrives. A long run of hits under a stalled consumer fills four queues and must drain exactly 528 entries, lowest column first, with `overflow` set. A sparse random stream with random stalls is then compared cycle by cycle against the model.

// File: rtl/sparse_cluster_finder.sv
module sparse_cluster_finder #(
  parameter int NCOL       = 16,
  parameter int PIX_W      = 5,
  parameter int ROW_W      = 8,
  parameter int FIFO_DEPTH = 132
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          row_valid,
  input  logic [NCOL*PIX_W-1:0]         row_data,
  input  logic [PIX_W+1:0]              threshold,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [$clog2(NCOL)-1:0]       out_col,
  output logic [ROW_W-1:0]              out_row,
  output logic [PIX_W-1:0]              out_val,
  output logic                          overflow
);
  localparam int CW    = $clog2(NCOL);
  localparam int SUM_W = PIX_W + 2;
  localparam int ENT_W = ROW_W + PIX_W;
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int LAG   = 4;
  localparam int HIST  = 6;

  logic [NCOL*PIX_W-1:0] line_q [LAG];
  logic [NCOL-1:0]       hmask_q [HIST];
  logic [2:0]            seen_q;
  logic [ROW_W-1:0]      rowcnt_q;

  logic [NCOL-1:0] hit, newmask, flag, push, drop, nonempty, full;
  logic [ENT_W-1:0] head [NCOL];
  logic [CW-1:0]   sel;
  logic            pop_en;
  wire  [ROW_W-1:0] emit_row = rowcnt_q - ROW_W'(LAG);
  wire              ready_rows = (seen_q == 3'(LAG));

  genvar gc, gd;
  generate
    for (gc = 0; gc < NCOL - 1; gc++) begin : g_kern
      wire [SUM_W-1:0] s = SUM_W'(line_q[0][gc*PIX_W +: PIX_W]) + SUM_W'(line_q[0][(gc+1)*PIX_W +: PIX_W])
                         + SUM_W'(row_data[gc*PIX_W +: PIX_W])  + SUM_W'(row_data[(gc+1)*PIX_W +: PIX_W]);
      assign hit[gc] = (seen_q != 3'd0) && (s > threshold);
    end
    assign hit[NCOL-1] = 1'b0;

    for (gc = 0; gc < NCOL; gc++) begin : g_dil
      logic [6:0] nb;
      for (gd = 0; gd < 7; gd++) begin : g_nb
        if (gc + gd - 3 >= 0 && gc + gd - 3 <= NCOL - 2) begin : g_in
          assign nb[gd] = hit[gc+gd-3];
        end else begin : g_out
          assign nb[gd] = 1'b0;
        end
      end
      assign newmask[gc] = |nb;
    end
  endgenerate

  always_comb begin
    flag = newmask;
    for (int i = 0; i < HIST; i++) flag = flag | hmask_q[i];
  end

  assign push = (row_valid && ready_rows) ? (flag & ~full) : '0;
  assign drop = (row_valid && ready_rows) ? (flag & full)  : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAG; i++)  line_q[i]  <= '0;
      for (int i = 0; i < HIST; i++) hmask_q[i] <= '0;
      seen_q   <= '0;
      rowcnt_q <= '0;
      overflow <= 1'b0;
    end else begin
      if (row_valid) begin
        line_q[0]  <= row_data;
        hmask_q[0] <= newmask;
        for (int i = 1; i < LAG; i++)  line_q[i]  <= line_q[i-1];
        for (int i = 1; i < HIST; i++) hmask_q[i] <= hmask_q[i-1];
        if (!ready_rows) seen_q <= seen_q + 3'd1;
        rowcnt_q <= rowcnt_q + 1'b1;
      end
      if (|drop) overflow <= 1'b1;
    end
  end

  generate
    for (gc = 0; gc < NCOL; gc++) begin : g_col
      logic [ENT_W-1:0] mem [FIFO_DEPTH];
      logic [AW-1:0]    wp, rp;
      logic [CNT_W-1:0] cnt;
      wire do_pop = pop_en && (sel == CW'(gc));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wp  <= '0;
          rp  <= '0;
          cnt <= '0;
        end else begin
          if (push[gc]) wp <= (wp == AW'(FIFO_DEPTH-1)) ? '0 : wp + 1'b1;
          if (do_pop)   rp <= (rp == AW'(FIFO_DEPTH-1)) ? '0 : rp + 1'b1;
          cnt <= cnt + CNT_W'(push[gc]) - CNT_W'(do_pop);
        end
      end

      always_ff @(posedge clk)
        if (push[gc]) mem[wp] <= {emit_row, line_q[LAG-1][gc*PIX_W +: PIX_W]};

      assign head[gc]     = mem[rp];
      assign nonempty[gc] = (cnt != '0);
      assign full[gc]     = (cnt == CNT_W'(FIFO_DEPTH));

      p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FIFO_DEPTH));
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = NCOL - 1; i >= 0; i--)
      if (nonempty[i]) sel = CW'(i);
  end

  assign out_valid = |nonempty;
  assign pop_en    = out_valid && out_ready;
  assign out_col   = sel;
  assign out_row   = head[sel][ENT_W-1:PIX_W];
  assign out_val   = head[sel][PIX_W-1:0];

  p_hold_rows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_rows |-> (push == '0));
  p_valid_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_drop_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|drop) |=> overflow);
endmodule

// File: tb/sparse_cluster_finder_tb.sv
module sparse_cluster_finder_tb_top;
  localparam int NCOL = 16, PIX_W = 5, ROW_W = 8, DEPTH = 132;

  logic clk = 1'b0, rst_n = 1'b0;
  logic row_valid = 1'b0, out_ready = 1'b0;
  logic [NCOL*PIX_W-1:0] row_data = '0;
  logic [PIX_W+1:0] threshold = '0;
  logic out_valid, overflow;
  logic [3:0] out_col;
  logic [ROW_W-1:0] out_row;
  logic [PIX_W-1:0] out_val;

  always #4 clk = ~clk;

  sparse_cluster_finder #(.NCOL(NCOL), .PIX_W(PIX_W), .ROW_W(ROW_W), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_data(row_data), .threshold(threshold),
    .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col), .out_row(out_row),
    .out_val(out_val), .overflow(overflow));

  int tests = 0, fails = 0, pops = 0, nrow = 0;
  bit done = 0, m_ovf = 0;
  int pix [0:2047][0:NCOL-1];
  int thr_at [0:2047];
  int cur [0:NCOL-1];
  int mq [NCOL][$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit flagged(int j, int c, int k);
    for (int a = j - 3; a <= j + 3; a++) begin
      if (a < 0 || a > k - 1) continue;
      for (int b = c - 3; b <= c + 3; b++) begin
        if (b < 0 || b > NCOL - 2) continue;
        if (pix[a][b] + pix[a][b+1] + pix[a+1][b] + pix[a+1][b+1] > thr_at[a+1]) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic step(input bit v, input int thr, input bit rdy);
    bit ev;
    int ec;
    bit pl [NCOL];
    @(negedge clk);
    ev = 0; ec = 0;
    for (int c = NCOL - 1; c >= 0; c--) if (mq[c].size() != 0) begin ev = 1; ec = c; end
    chk(out_valid == ev, "R8 out_valid", int'(out_valid), int'(ev));
    if (ev && out_valid) begin
      chk(int'(out_col) == ec, "R8 out_col", int'(out_col), ec);
      chk(int'(out_row) == mq[ec][0] / 32, "R1/R6 out_row", int'(out_row), mq[ec][0] / 32);
      chk(int'(out_val) == mq[ec][0] % 32, "R5 out_val", int'(out_val), mq[ec][0] % 32);
    end
    chk(overflow == m_ovf, "R9 overflow", int'(overflow), int'(m_ovf));
    if (out_valid && rdy) pops++;
    row_valid = v; out_ready = rdy; threshold = 7'(thr);
    for (int c = 0; c < NCOL; c++) row_data[c*PIX_W +: PIX_W] = 5'(cur[c]);
    @(posedge clk);
    for (int c = 0; c < NCOL; c++) pl[c] = 0;
    if (v) begin
      for (int c = 0; c < NCOL; c++) pix[nrow][c] = cur[c];
      thr_at[nrow] = thr;
      if (nrow >= 4)
        for (int c = 0; c < NCOL; c++)
          if (flagged(nrow - 4, c, nrow)) begin
            if (mq[c].size() >= DEPTH) m_ovf = 1; else pl[c] = 1;
          end
    end
    if (ev && rdy) void'(mq[ec].pop_front());
    for (int c = 0; c < NCOL; c++)
      if (pl[c]) mq[c].push_back(((nrow - 4) % 256) * 32 + pix[nrow-4][c]);
    if (v) nrow++;
  endtask

  task automatic zero_row();
    for (int c = 0; c < NCOL; c++) cur[c] = 0;
  endtask

  task automatic rows_zero(input int n, input int thr);
    zero_row();
    for (int i = 0; i < n; i++) step(1, thr, 1);
  endtask

  task automatic idle(input int n, input bit rdy);
    for (int i = 0; i < n; i++) step(0, 100, rdy);
  endtask

  task automatic pair_hit(input int c, input int thr_up, input int thr_low);
    zero_row(); cur[c] = 10; cur[c+1] = 10;
    step(1, thr_up, 1);
    step(1, thr_low, 1);
  endtask

  initial begin
    zero_row();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset out_valid", int'(out_valid), 0);
    chk(overflow == 1'b0, "R10 reset overflow", int'(overflow), 0);
    rst_n = 1'b1;

    pops = 0; pair_hit(7, 39, 39); rows_zero(8, 39); idle(60, 1);
    chk(pops == 28, "R4 top-edge clip count", pops, 28);

    rows_zero(4, 100); pops = 0; pair_hit(7, 39, 39); rows_zero(8, 100); idle(80, 1);
    chk(pops == 49, "R4 lone hit 7x7 count", pops, 49);

    pops = 0; pair_hit(7, 40, 40); rows_zero(8, 100); idle(40, 1);
    chk(pops == 0, "R2 sum equal to threshold", pops, 0);

    pops = 0; pair_hit(14, 39, 39); rows_zero(8, 100); idle(60, 1);
    chk(pops == 35, "R4 right-edge clip count", pops, 35);

    pops = 0; pair_hit(0, 39, 39); rows_zero(8, 100); idle(60, 1);
    chk(pops == 28, "R4 left-edge clip count", pops, 28);

    pops = 0; pair_hit(4, 39, 39); rows_zero(0, 100); pair_hit(7, 39, 39); rows_zero(10, 100); idle(120, 1);
    chk(pops == 78, "R5 merged overlap count", pops, 78);

    pops = 0; pair_hit(7, 100, 39); rows_zero(8, 100); idle(80, 1);
    chk(pops == 49, "R3 threshold at lower row", pops, 49);
    pops = 0; pair_hit(7, 39, 100); rows_zero(8, 39); idle(40, 1);
    chk(pops == 0, "R3 threshold at lower row, high", pops, 0);

    zero_row(); cur[0] = 10; cur[1] = 10;
    for (int i = 0; i < 150; i++) step(1, 39, 0);
    chk(overflow == 1'b1 || m_ovf == 1'b0, "R9 overflow after fill", int'(overflow), 1);
    pops = 0; idle(600, 1);
    chk(pops == 4 * DEPTH, "R7 drained entries", pops, 4 * DEPTH);
    chk(m_ovf == 1'b1, "R9 model overflow expected", int'(m_ovf), 1);
    rows_zero(10, 100); idle(60, 1);

    void'($urandom(7));
    for (int i = 0; i < 300; i++) begin
      for (int c = 0; c < NCOL; c++)
        cur[c] = ($urandom % 100 < 3) ? 8 + int'($urandom % 24) : int'($urandom % 4);
      step(($urandom % 5) != 0, 30, ($urandom % 4) != 0);
    end
    rows_zero(10, 100); idle(300, 1);
    chk(out_valid == 1'b0, "R8 drained at end", int'(out_valid), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule